// File: doc/BRIEF.md
# Flash Status Polling Toggle Logic

This block forms the word a flash device returns to a read while an internal program or erase is in progress or while an erase is suspended. Each qualified read strobe either returns a status byte or passes the array read data through, and it advances the two toggle bits that software polls to see whether the device is still busy. The operation mode, the erase-sector hit flag, the two status bits computed by the erase controller and the array data all come from neighbouring logic. Address decoding and erase timing live elsewhere.

The two toggle bits follow different rules. This lets software tell a program from an erase, and tell a suspended sector from one that can be read normally. Bit 6 inverts on every status read of a program or an erase. Bit 2 inverts only on erase-related status reads, and it keeps doing so during suspend for sectors that are being erased. During suspend, reads of any other sector return plain array data.

Top module: `flash_poll_status`

## Requirements
- R1: While reset is asserted and right after it is released, rd_data_o is all zeros, rd_valid_o is 0, and both toggle bits start at 0.
- R2: In idle mode (op_mode_i = 0), a strobed read returns array_data_i and leaves both toggle bits unchanged.
- R3: In program mode (op_mode_i = 1), a strobed read returns the status byte, inverts toggle bit 6 and leaves toggle bit 2 unchanged.
- R4: In erase mode (op_mode_i = 2), a strobed read returns the status byte and inverts both toggle bits, whatever the value of sect_erasing_i.
- R5: In suspend mode (op_mode_i = 3) with sect_erasing_i = 1, a strobed read returns the status byte, inverts toggle bit 2 and leaves toggle bit 6 unchanged.
- R6: In suspend mode with sect_erasing_i = 0, a strobed read returns array_data_i, leaves both toggle bits unchanged, and repeated reads of unchanged data return the same value.
- R7: The status byte carries erase_dq7_i at bit 7, toggle bit 6 at bit 6, erase_dq3_i at bit 3 and toggle bit 2 at bit 2. Bits 5, 4, 1 and 0 are 0. The toggle values shown are the ones held before the read's own update.
- R8: When DATA_W is wider than 8, the status byte is copied into every byte lane of rd_data_o.
- R9: The toggle bits change only on a cycle with rd_stb_i high, so two status reads of the same kind show opposite toggle values even when idle cycles separate them.
- R10: With the default registered output, rd_data_o and rd_valid_o update on the clock edge that samples rd_stb_i. rd_valid_o is high for exactly one cycle per strobe, and rd_data_o holds its value when no strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mode_i | input | 2 | 0 idle, 1 program, 2 erase, 3 erase suspended |
| sect_erasing_i | input | 1 | Read address falls in a sector scheduled for erase |
| erase_dq7_i | input | 1 | Bit 7 value from the erase controller |
| erase_dq3_i | input | 1 | Bit 3 value from the erase controller (0 while more erase commands are accepted) |
| array_data_i | input | DATA_W | Array read data |
| rd_stb_i | input | 1 | Qualified read strobe |
| rd_data_o | output | DATA_W | Read result, either status or array data |
| rd_valid_o | output | 1 | Read result valid |

## Verification
Every cycle, the assertions check the per-mode toggle rules: which bit inverts and which holds on a strobe in each mode, and that nothing moves without a strobe. They also check the pass-through of array data and the one-cycle valid pulse. Only the bench's scenarios can show the composite output: the bit layout of the status byte, its copy into both lanes of the 16-bit bus, and the alternation software sees across long mixed sequences. In those sequences, idle cycles, mode changes and suspend reads to erasing and non-erasing sectors are interleaved, so a bit that slips or a toggle that is lost shows up on a later read.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

   typedef enum logic [1:0] {
      FP_IDLE  = 2'd0,
      FP_PROG  = 2'd1,
      FP_ERASE = 2'd2,
      FP_SUSP  = 2'd3
   } fp_mode_e;

   localparam int unsigned FP_BIT_BUSY  = 7;
   localparam int unsigned FP_BIT_TGL_A = 6;
   localparam int unsigned FP_BIT_WIN   = 3;
   localparam int unsigned FP_BIT_TGL_B = 2;

   typedef struct packed {
      logic show_status;
      logic flip_a;
      logic flip_b;
   } fp_action_t;

   function automatic fp_action_t fp_decode(input fp_mode_e mode, input logic hit);
      fp_action_t act;
      act = '0;
      unique case (mode)
         FP_IDLE:  act = '{show_status: 1'b0, flip_a: 1'b0, flip_b: 1'b0};
         FP_PROG:  act = '{show_status: 1'b1, flip_a: 1'b1, flip_b: 1'b0};
         FP_ERASE: act = '{show_status: 1'b1, flip_a: 1'b1, flip_b: 1'b1};
         FP_SUSP:  act = '{show_status: hit,  flip_a: 1'b0, flip_b: hit};
         default:  act = '0;
      endcase
      return act;
   endfunction

endpackage

// File: rtl/fps_toggle_ctrl.sv
module fps_toggle_ctrl
   import flash_poll_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     rd_stb,
   input  fp_mode_e mode,
   input  logic     hit,
   output logic     tgl_a,
   output logic     tgl_b,
   output logic     show_status
);

   fp_action_t act;

   always_comb begin
      act         = fp_decode(mode, hit);
      show_status = act.show_status;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgl_a <= 1'b0;
         tgl_b <= 1'b0;
      end else if (rd_stb) begin
         if (act.flip_a) tgl_a <= ~tgl_a;
         if (act.flip_b) tgl_b <= ~tgl_b;
      end
   end

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && mode == FP_IDLE) |=> ($stable(tgl_a) && $stable(tgl_b)));

   p_prog_a_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && mode == FP_PROG) |=> ((tgl_a != $past(tgl_a)) && $stable(tgl_b)));

   p_erase_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && mode == FP_ERASE) |=> ((tgl_a != $past(tgl_a)) && (tgl_b != $past(tgl_b))));

   p_susp_hit_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && mode == FP_SUSP && hit) |=> ($stable(tgl_a) && (tgl_b != $past(tgl_b))));

   p_susp_miss_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && mode == FP_SUSP && !hit) |=> ($stable(tgl_a) && $stable(tgl_b)));

   p_no_strobe_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> ($stable(tgl_a) && $stable(tgl_b)));

endmodule

// File: rtl/fps_status_fmt.sv
module fps_status_fmt
   import flash_poll_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              busy_bit,
   input  logic              win_bit,
   input  logic              tgl_a,
   input  logic              tgl_b,
   output logic [DATA_W-1:0] status_word
);

   localparam int unsigned LANES = DATA_W / 8;

   logic [7:0] status_byte;

   always_comb begin
      status_byte               = 8'h00;
      status_byte[FP_BIT_BUSY]  = busy_bit;
      status_byte[FP_BIT_TGL_A] = tgl_a;
      status_byte[FP_BIT_WIN]   = win_bit;
      status_byte[FP_BIT_TGL_B] = tgl_b;
   end

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      assign status_word[ln*8 +: 8] = status_byte;
   end

endmodule

// File: rtl/fps_out_stage.sv
module fps_out_stage #(
   parameter int unsigned DATA_W  = 16,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_stb,
   input  logic              show_status,
   input  logic [DATA_W-1:0] status_word,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);

   logic [DATA_W-1:0] sel_word;

   assign sel_word = show_status ? status_word : array_data;

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
         end else begin
            rd_valid <= rd_stb;
            if (rd_stb) rd_data <= sel_word;
         end
      end

      p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
         rd_stb |=> rd_valid);

      p_valid_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_stb |=> !rd_valid);

      p_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_stb |=> $stable(rd_data));

      p_array_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_stb && !show_status) |=> (rd_data == $past(array_data)));
   end else begin : g_comb
      assign rd_data  = sel_word;
      assign rd_valid = rd_stb;
   end

endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
   import flash_poll_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        op_mode_i,
   input  logic              sect_erasing_i,
   input  logic              erase_dq7_i,
   input  logic              erase_dq3_i,
   input  logic [DATA_W-1:0] array_data_i,
   input  logic              rd_stb_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_valid_o
);

   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("flash_poll_status: DATA_W must be a positive multiple of 8");
   end

   fp_mode_e          mode;
   logic              tgl_a;
   logic              tgl_b;
   logic              show_status;
   logic [DATA_W-1:0] status_word;

   assign mode = fp_mode_e'(op_mode_i);

   fps_toggle_ctrl u_toggle (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_stb      (rd_stb_i),
      .mode        (mode),
      .hit         (sect_erasing_i),
      .tgl_a       (tgl_a),
      .tgl_b       (tgl_b),
      .show_status (show_status)
   );

   fps_status_fmt #(.DATA_W(DATA_W)) u_fmt (
      .busy_bit    (erase_dq7_i),
      .win_bit     (erase_dq3_i),
      .tgl_a       (tgl_a),
      .tgl_b       (tgl_b),
      .status_word (status_word)
   );

   fps_out_stage #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_stb      (rd_stb_i),
      .show_status (show_status),
      .status_word (status_word),
      .array_data  (array_data_i),
      .rd_data     (rd_data_o),
      .rd_valid    (rd_valid_o)
   );

endmodule

// File: tb/test_flash_poll_status.sv
module test_flash_poll_status;

   localparam int CLK_PERIOD = 10;
   localparam int DW         = 16;
   localparam int WATCHDOG   = 200000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    op_mode = 2'd0;
   logic          hit = 1'b0;
   logic          dq7 = 1'b0;
   logic          dq3 = 1'b0;
   logic [DW-1:0] adata = '0;
   logic          stb = 1'b0;
   logic [DW-1:0] rd_data;
   logic          rd_valid;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   // reference model state
   bit            m_a = 1'b0;
   bit            m_b = 1'b0;
   logic [DW-1:0] m_data = '0;
   bit            m_valid = 1'b0;

   flash_poll_status #(.DATA_W(DW)) i_flash_poll_status (
      .clk            (clk),
      .rst_n          (rst_n),
      .op_mode_i      (op_mode),
      .sect_erasing_i (hit),
      .erase_dq7_i    (dq7),
      .erase_dq3_i    (dq3),
      .array_data_i   (adata),
      .rd_stb_i       (stb),
      .rd_data_o      (rd_data),
      .rd_valid_o     (rd_valid)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // R7 / R8: status byte layout, copied to both lanes
   function automatic logic [DW-1:0] ref_status(bit a, bit b, bit s7, bit s3);
      logic [7:0] by;
      by = {s7, a, 2'b00, s3, b, 2'b00};
      return {by, by};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_a = 1'b0; m_b = 1'b0; m_data = '0; m_valid = 1'b0;
      end else begin
         m_valid = stb;
         if (stb) begin
            bit st;
            bit fa;
            bit fb;
            st = (op_mode == 2'd1) || (op_mode == 2'd2) || (op_mode == 2'd3 && hit);
            fa = (op_mode == 2'd1) || (op_mode == 2'd2);
            fb = (op_mode == 2'd2) || (op_mode == 2'd3 && hit);
            m_data = st ? ref_status(m_a, m_b, dq7, dq3) : adata;
            if (fa) m_a = !m_a;
            if (fb) m_b = !m_b;
         end
      end
   end

   task automatic compare();
      n_cmp++;
      if (rd_valid !== m_valid || rd_data !== m_data) begin
         n_bad++;
         $display("FAIL %s: rd_valid=%0b rd_data=%h expected rd_valid=%0b rd_data=%h",
                  cur_req, rd_valid, rd_data, m_valid, m_data);
      end
   endtask

   task automatic cyc(input logic [1:0] m, input logic h, input logic s7,
                      input logic s3, input logic [DW-1:0] d, input logic s);
      op_mode = m; hit = h; dq7 = s7; dq3 = s3; adata = d; stb = s;
      @(negedge clk);
      compare();
   endtask

   task automatic own_check(input bit ok, input string req,
                            input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [DW-1:0] v0, v1;
      @(negedge clk);
      // R1: reset state, strobes during reset are ignored
      cur_req = "R1";
      cyc(2'd2, 1'b1, 1'b1, 1'b1, 16'hBEEF, 1'b1);
      cyc(2'd2, 1'b1, 1'b1, 1'b1, 16'hBEEF, 1'b0);
      own_check(rd_data === '0 && rd_valid === 1'b0, "R1", rd_data, '0);
      rst_n = 1'b1;
      cyc(2'd0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0);
      own_check(rd_valid === 1'b0, "R1", {15'd0, rd_valid}, '0);
      // R1/R7: first status shows toggles at 0
      cyc(2'd1, 1'b0, 1'b0, 1'b0, 16'h1234, 1'b1);
      own_check(rd_data === 16'h0000, "R1", rd_data, 16'h0000);

      // R2: idle reads return data, toggles untouched
      cur_req = "R2";
      for (int i = 0; i < 6; i++) cyc(2'd0, i[0], 1'b1, 1'b1, 16'(16'hA5C3 ^ (i * 16'h1111)), 1'b1);

      // R3: program reads toggle bit 6 only
      cur_req = "R3";
      cyc(2'd1, 1'b0, 1'b0, 1'b0, 16'hFFFF, 1'b1); v0 = rd_data;
      cyc(2'd1, 1'b0, 1'b0, 1'b0, 16'hFFFF, 1'b1); v1 = rd_data;
      own_check(((v0 ^ v1) & 16'h4444) == 16'h4040, "R3", v0 ^ v1, 16'h4040);

      // R4: erase reads toggle both, regardless of hit
      cur_req = "R4";
      cyc(2'd2, 1'b0, 1'b0, 1'b0, 16'h0F0F, 1'b1); v0 = rd_data;
      cyc(2'd2, 1'b1, 1'b0, 1'b0, 16'h0F0F, 1'b1); v1 = rd_data;
      own_check(((v0 ^ v1) & 16'h4444) == 16'h4444, "R4", v0 ^ v1, 16'h4444);
      cyc(2'd2, 1'b1, 1'b0, 1'b1, 16'h0F0F, 1'b1);

      // R9: idle cycles between status reads do not move the toggles
      cur_req = "R9";
      cyc(2'd2, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1); v0 = rd_data;
      for (int i = 0; i < 5; i++) cyc(2'd2, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b0);
      cyc(2'd2, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1); v1 = rd_data;
      own_check(((v0 ^ v1) & 16'h4444) == 16'h4444, "R9", v0 ^ v1, 16'h4444);

      // R5: suspend read of an erasing sector toggles bit 2 only
      cur_req = "R5";
      cyc(2'd3, 1'b1, 1'b0, 1'b0, 16'h7777, 1'b1); v0 = rd_data;
      cyc(2'd3, 1'b1, 1'b0, 1'b0, 16'h7777, 1'b1); v1 = rd_data;
      own_check(((v0 ^ v1) & 16'h4444) == 16'h0404, "R5", v0 ^ v1, 16'h0404);

      // R6: suspend read of another sector returns stable data
      cur_req = "R6";
      cyc(2'd3, 1'b0, 1'b0, 1'b0, 16'h5A96, 1'b1); v0 = rd_data;
      cyc(2'd3, 1'b0, 1'b0, 1'b0, 16'h5A96, 1'b1); v1 = rd_data;
      own_check(v0 === 16'h5A96 && v1 === v0, "R6", v1, 16'h5A96);

      // R7/R8: status bit layout for all busy/window combinations, both lanes
      cur_req = "R7";
      for (int i = 0; i < 4; i++) cyc(2'd1, 1'b0, i[1], i[0], 16'h3C3C, 1'b1);
      cur_req = "R8";
      cyc(2'd2, 1'b0, 1'b1, 1'b1, 16'h0000, 1'b1);
      own_check(rd_data[15:8] === rd_data[7:0], "R8", rd_data, {rd_data[7:0], rd_data[7:0]});

      // R10: valid pulse timing and data hold
      cur_req = "R10";
      cyc(2'd0, 1'b0, 1'b0, 1'b0, 16'hC001, 1'b1);
      cyc(2'd0, 1'b0, 1'b0, 1'b0, 16'hD00D, 1'b0);
      own_check(rd_valid === 1'b0 && rd_data === 16'hC001, "R10", rd_data, 16'hC001);

      // mixed long sequence
      cur_req = "R9";
      for (int i = 0; i < 3000; i++)
         cyc(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), 16'($urandom), 1'($urandom_range(0, 2) != 0));

      finish_run();
   end

endmodule